// File: doc/BRIEF.md
# Vertical Sync Mode Recognition Controller

This block sits beside a field-rate line counter in a countdown video timing chain. It decides whether the counter follows the incoming integrated vertical sync (standard, locked mode) or runs freely on its own (non-synchronous mode). Once per field it compares the incoming sync with the counter's own vertical pulse. In the same field it counts equalizing strobes that arrive inside the vertical drive window, and sync edges that arrive during active scan, which it treats as noise.

In free-running mode the block asks the counter to re-phase on every rising edge of the incoming sync. In standard mode it stops asking, and it holds that mode across a run of bad fields. A run of clean, coincident fields with a full set of equalizing pulses locks the block. A noisy field arms a shortcut that locks on the next coincident field. A force input, tied high when it is not used, keeps the block free-running.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While reset is held and after it is released, before any field event, `std_mode_o` and `phase_rst_o` are 0.
- R2: A field ends on the cycle where `vpulse_i` is 1. The field is coincident when `iv_sync_i` is 1 in that cycle. `std_mode_o` rises in the cycle after the end of the 7th consecutive coincident field, provided 9 or more `eq_strobe_i` cycles were seen while `drive_win_i` was 1 in that field. Strobes in the end-of-field cycle itself are not counted.
- R3: A coincident run with only 8 qualified equalizing strobes per field does not enter standard mode.
- R4: A non-coincident field restarts the coincident-field count from zero.
- R5: In standard mode the block stays in standard mode through up to 7 consecutive non-coincident fields. A coincident field restarts that count.
- R6: The 8th consecutive non-coincident field in standard mode returns `std_mode_o` to 0 in the following cycle.
- R7: Two or more rising edges of `iv_sync_i` while `active_scan_i` is 1, within one field, arm a fast path. The next coincident field then enters standard mode without the coincident-field run and without equalizing strobes.
- R8: Noise and equalizing counts start again at every end of field, so single noise edges in two separate fields do not arm the fast path.
- R9: While `force_async_i` is 1, `std_mode_o` is 0 from the next cycle on. The coincident-field count, the bad-field count and the fast-path arming are cleared.
- R10: `phase_rst_o` is a one-cycle pulse in the cycle after a rising edge of `iv_sync_i` when `std_mode_o` was 0 in the edge cycle. It is never asserted following an edge seen in standard mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iv_sync_i | input | 1 | Integrated vertical sync, already shaped |
| vpulse_i | input | 1 | One-cycle strobe from the counter's internal vertical pulse, marking the end of a field |
| eq_strobe_i | input | 1 | One-cycle strobe per detected equalizing pulse |
| active_scan_i | input | 1 | High during the active scan lines |
| drive_win_i | input | 1 | High during the vertical drive window |
| force_async_i | input | 1 | Forces free-running mode when 1 |
| std_mode_o | output | 1 | 1 = standard (locked) mode, registered |
| phase_rst_o | output | 1 | Re-phase request to the counter, registered |

## Verification
The hardest state to reach is a standard-mode dwell that has counted exactly seven bad fields. To get there, the stimulus must first lock the block through a full seven-field qualified run. It then feeds bad fields, breaks the run with one good field, and feeds eight more bad fields. Only then does the boundary between hold and drop show at the mode output. The fast path is reached by following a clean free-running stretch with a non-coincident field that carries two active-scan edges, and then a bare coincident field. A behavioural model in the bench tracks every cycle of this, including the re-phase pulses caused by the noise edges.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;
  localparam int LOCK_FIELDS_DEF = 7;
  localparam int HOLD_FIELDS_DEF = 7;
  localparam int EQ_MIN_DEF      = 9;
  localparam int NOISE_MIN_DEF   = 2;

  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_STD  = 1'b1
  } mode_e;
endpackage

// File: rtl/smr_edge_det.sv
module smr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/smr_sat_cnt.sv
module smr_sat_cnt #(
  parameter int MAX = 7,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  logic [W-1:0] cnt_q;

  // clear wins over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX_V) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_V);
  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
#(
  parameter int LOCK_FIELDS = LOCK_FIELDS_DEF,
  parameter int HOLD_FIELDS = HOLD_FIELDS_DEF,
  parameter int EQ_MIN      = EQ_MIN_DEF,
  parameter int NOISE_MIN   = NOISE_MIN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic iv_sync_i,
  input  logic vpulse_i,
  input  logic eq_strobe_i,
  input  logic active_scan_i,
  input  logic drive_win_i,
  input  logic force_async_i,
  output logic std_mode_o,
  output logic phase_rst_o
);
  localparam int CW = $clog2(LOCK_FIELDS + 1);
  localparam int BW = $clog2(HOLD_FIELDS + 1);
  localparam int EW = $clog2(EQ_MIN + 1);
  localparam int NW = $clog2(NOISE_MIN + 1);
  localparam logic [CW-1:0] COIN_PRE = CW'(LOCK_FIELDS - 1);
  localparam logic [BW-1:0] BAD_TOP  = BW'(HOLD_FIELDS);
  localparam logic [EW-1:0] EQ_THR   = EW'(EQ_MIN);
  localparam logic [NW-1:0] NOISE_THR = NW'(NOISE_MIN);

  mode_e mode_q, mode_d;
  logic  arm_q, arm_d;
  logic  phase_q;
  logic  std_q;
  logic  iv_rise;
  logic  enter, drop;
  logic  noise_ok, eq_ok, coin_ready, bad_full;

  logic [CW-1:0] coin_cnt;
  logic [BW-1:0] bad_cnt;
  logic [EW-1:0] eq_cnt;
  logic [NW-1:0] noise_cnt;

  assign std_q = (mode_q == MODE_STD);

  smr_edge_det u_iv_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (iv_sync_i),
    .rise_o (iv_rise)
  );

  // per-field noise and equalizing counts
  smr_sat_cnt #(.MAX(NOISE_MIN)) u_noise_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vpulse_i),
    .inc_i  (active_scan_i & iv_rise),
    .cnt_o  (noise_cnt)
  );

  smr_sat_cnt #(.MAX(EQ_MIN)) u_eq_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vpulse_i),
    .inc_i  (drive_win_i & eq_strobe_i),
    .cnt_o  (eq_cnt)
  );

  // field-rate run counters
  smr_sat_cnt #(.MAX(LOCK_FIELDS)) u_coin_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (force_async_i | (vpulse_i & ~iv_sync_i)),
    .inc_i  (vpulse_i & iv_sync_i),
    .cnt_o  (coin_cnt)
  );

  smr_sat_cnt #(.MAX(HOLD_FIELDS)) u_bad_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (force_async_i | (vpulse_i & (iv_sync_i | ~std_q | drop))),
    .inc_i  (vpulse_i & std_q & ~iv_sync_i),
    .cnt_o  (bad_cnt)
  );

  assign noise_ok   = (noise_cnt == NOISE_THR);
  assign eq_ok      = (eq_cnt == EQ_THR);
  assign coin_ready = (coin_cnt >= COIN_PRE);
  assign bad_full   = (bad_cnt == BAD_TOP);

  assign enter = vpulse_i & ~std_q & iv_sync_i &
                 (noise_ok | arm_q | (eq_ok & coin_ready));
  assign drop  = vpulse_i & std_q & ~iv_sync_i & bad_full;

  always_comb begin
    mode_d = mode_q;
    arm_d  = arm_q;
    if (force_async_i) begin
      mode_d = MODE_FREE;
      arm_d  = 1'b0;
    end else if (vpulse_i) begin
      if (enter)     mode_d = MODE_STD;
      else if (drop) mode_d = MODE_FREE;
      arm_d = ~std_q & ~enter & (arm_q | noise_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_FREE;
      arm_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      arm_q   <= arm_d;
      phase_q <= iv_rise & ~std_q;
    end
  end

  assign std_mode_o  = std_q;
  assign phase_rst_o = phase_q;

  p_force_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_async_i |=> !std_mode_o);
  p_enter_at_field_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(std_mode_o) |-> $past(vpulse_i) && $past(iv_sync_i));
  p_leave_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(std_mode_o) |-> $past(force_async_i) || ($past(vpulse_i) && !$past(iv_sync_i)));
  p_phase_free_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_rst_o |-> !$past(std_mode_o));
  p_phase_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_rst_o |=> !phase_rst_o);
endmodule

// File: tb/sync_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module sync_mode_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic iv_sync_i = 1'b0, vpulse_i = 1'b0, eq_strobe_i = 1'b0;
  logic active_scan_i = 1'b0, drive_win_i = 1'b0, force_async_i = 1'b0;
  logic std_mode_o, phase_rst_o;

  int checks = 0;
  int errors = 0;
  int phase_seen = 0;

  always #10 clk_i = ~clk_i;

  sync_mode_ctrl dut_i (
    .clk_i, .rst_ni, .iv_sync_i, .vpulse_i, .eq_strobe_i,
    .active_scan_i, .drive_win_i, .force_async_i, .std_mode_o, .phase_rst_o
  );

  // behavioural reference
  int m_std, m_phase, m_coin, m_bad, m_eq, m_noise, m_arm, m_ivd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_std = 0; m_phase = 0; m_coin = 0; m_bad = 0;
      m_eq = 0; m_noise = 0; m_arm = 0; m_ivd = 0;
    end else begin
      int rise, nxt_phase, noisy, full_eq;
      rise = (iv_sync_i && !m_ivd) ? 1 : 0;
      nxt_phase = (rise && !m_std) ? 1 : 0;
      noisy = (m_noise >= 2) ? 1 : 0;
      full_eq = (m_eq >= 9) ? 1 : 0;
      if (force_async_i) begin
        m_std = 0; m_coin = 0; m_bad = 0; m_arm = 0;
      end else if (vpulse_i) begin
        if (!m_std) begin
          m_bad = 0;
          if (iv_sync_i && (noisy || m_arm || (full_eq && m_coin >= 6))) begin
            m_std = 1; m_arm = 0;
          end else begin
            m_arm = (m_arm || noisy) ? 1 : 0;
          end
        end else begin
          m_arm = 0;
          if (iv_sync_i) m_bad = 0;
          else begin
            m_bad++;
            if (m_bad == 8) begin m_std = 0; m_bad = 0; end
          end
        end
      end
      if (!force_async_i && vpulse_i)
        m_coin = iv_sync_i ? ((m_coin < 7) ? m_coin + 1 : 7) : 0;
      if (vpulse_i) begin
        m_noise = 0; m_eq = 0;
      end else begin
        if (active_scan_i && rise && m_noise < 3) m_noise++;
        if (drive_win_i && eq_strobe_i && m_eq < 15) m_eq++;
      end
      m_ivd = iv_sync_i;
      m_phase = nxt_phase;
    end
  end

  // per-clock compare, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (std_mode_o !== m_std[0] || phase_rst_o !== m_phase[0]) begin
        errors++;
        $display("FAIL R2 R10 model compare: actual std=%0b phase=%0b expected std=%0d phase=%0d",
                 std_mode_o, phase_rst_o, m_std, m_phase);
      end
      if (phase_rst_o === 1'b1) phase_seen++;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic field(input logic coin, input int neq, input int nnoise);
    step(); active_scan_i = 1'b1;
    for (int i = 0; i < nnoise; i++) begin
      step(); iv_sync_i = 1'b1;
      step(); iv_sync_i = 1'b0;
      step();
    end
    repeat (3) step();
    active_scan_i = 1'b0;
    step(); drive_win_i = 1'b1;
    for (int i = 0; i < neq; i++) begin
      step(); eq_strobe_i = 1'b1;
      step(); eq_strobe_i = 1'b0;
    end
    step(); drive_win_i = 1'b0;
    step(); iv_sync_i = coin;
    step(); vpulse_i = 1'b1;
    step(); vpulse_i = 1'b0; iv_sync_i = 1'b0;
  endtask

  task automatic force_pulse();
    step(); force_async_i = 1'b1;
    step(); force_async_i = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R1 std during reset", std_mode_o, 1'b0);
    check("R1 phase during reset", phase_rst_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) step();
    check("R1 std after reset", std_mode_o, 1'b0);

    // R2: qualified lock after seven fields
    phase_seen = 0;
    for (int f = 0; f < 6; f++) field(1'b1, 9, 0);
    check("R2 not yet locked after 6", std_mode_o, 1'b0);
    check("R10 re-phase while free", phase_seen > 0, 1'b1);
    field(1'b1, 9, 0);
    check("R2 locked after 7", std_mode_o, 1'b1);

    // R5/R6 hold and drop
    phase_seen = 0;
    field(1'b1, 9, 2);
    check("R10 no re-phase while locked", phase_seen == 0, 1'b1);
    for (int f = 0; f < 7; f++) field(1'b0, 0, 0);
    check("R5 held through 7 bad", std_mode_o, 1'b1);
    field(1'b1, 0, 0);
    for (int f = 0; f < 7; f++) field(1'b0, 0, 0);
    check("R5 good field restarts bad run", std_mode_o, 1'b1);
    field(1'b0, 0, 0);
    check("R6 dropped on 8th bad", std_mode_o, 1'b0);

    // R3: eight strobes never enough
    for (int f = 0; f < 8; f++) field(1'b1, 8, 0);
    check("R3 short equalizing run", std_mode_o, 1'b0);

    // R4: broken run restarts
    force_pulse();
    for (int f = 0; f < 6; f++) field(1'b1, 9, 0);
    field(1'b0, 9, 0);
    for (int f = 0; f < 6; f++) field(1'b1, 9, 0);
    check("R4 run restarted", std_mode_o, 1'b0);
    field(1'b1, 9, 0);
    check("R4 locked after fresh 7", std_mode_o, 1'b1);

    // R9: force
    step(); force_async_i = 1'b1;
    step(); step();
    check("R9 forced free", std_mode_o, 1'b0);
    field(1'b1, 9, 2);
    check("R9 stays free under force", std_mode_o, 1'b0);
    step(); force_async_i = 1'b0;

    // R8: noise does not span fields
    field(1'b1, 0, 1);
    field(1'b1, 0, 1);
    check("R8 split noise not armed", std_mode_o, 1'b0);

    // R7: fast path
    field(1'b0, 0, 2);
    check("R7 armed but not coincident", std_mode_o, 1'b0);
    field(1'b1, 0, 0);
    check("R7 fast lock", std_mode_o, 1'b1);

    repeat (4) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule